// File: doc/BRIEF.md
# GPIO Bank with Per-Line Interrupt Sensing

This block is a bank of general-purpose I/O lines behind a plain word-wide register bus. Every line is set up on its own as a plain input, a plain output, or an interrupt input. An interrupt line chooses its polarity, edge or level sensing, and single-edge or dual-edge capture. Each line owns a pending flag. Software clears a flag by writing a one to it. A mask word that is set and cleared through two separate write addresses gates the flags, and one registered interrupt output combines every enabled pending flag.

Pad inputs go through a multi-flop synchroniser before anything uses them. Software reads the synchronised pad level through an input-enable gate. An output line drives either the bank's own output data word or an alternate data input, chosen per line. The bus has no handshake: a write takes effect on the clock edge at which `bus_we` is high, and read data is a combinational function of `bus_addr`.

Register byte offsets: 0x00 line mode, 0x04 direction, 0x08 output data, 0x0C input data, 0x10 pending, 0x14 pending clear, 0x18 mask (AND write), 0x1C mask set (OR write), 0x20 polarity, 0x24 edge/level, 0x40 output source, 0x4C dual-edge, 0x50 input enable. Any other offset reads zero and ignores writes.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, `pad_oe`, `pad_out` and `irq` are 0, and every line is a masked general input. Unmapped offsets (for example 0x28) read 0.
- R2: A line drives its pad (`pad_oe`=1) only when its mode bit (0x00) is 0 (general I/O) and its direction bit (0x04) is 1 (output). A mode bit of 1 (interrupt input) turns the driver off.
- R3: `pad_out` of a line is the output data bit (0x08) when its source bit (0x40) is 0, and `alt_data` when it is 1. `pad_out` follows the output data bit even while the driver is off, so the value is already set when the line becomes an output.
- R4: The input data word (0x0C) returns the pad level after a two-flop synchroniser, ANDed with the input-enable bit (0x50). It shows the pad of an output line too. A pad change is visible there at the second clock edge after it.
- R5: In interrupt mode with edge sensing (0x24 bit = 1) and dual-edge off, polarity 0 (0x20) captures rising edges and polarity 1 captures falling edges. The pending bit (0x10) sets at the third clock edge after the pad changes, which is one edge after the synchronised transition.
- R6: With edge sensing and the dual-edge bit (0x4C) set, both edges set the pending bit and the polarity bit is ignored.
- R7: With level sensing (0x24 bit = 0), the pending bit follows the active level: high for polarity 0, low for polarity 1. A pending-clear write while the level is active has no lasting effect.
- R8: Writing 1 to a bit of the pending-clear word (0x14) clears an edge-captured pending bit, and a 0 bit leaves it unchanged. The word reads 0. A capture in the same cycle as a clear write wins.
- R9: A write to 0x18 clears each mask bit written as 0 and keeps those written as 1. A write to 0x1C sets each mask bit written as 1. 0x18 reads the mask, and 0x1C reads 0. A mask bit of 1 enables the line.
- R10: `irq` is a register loaded with the OR over all lines of pending AND mask, so it changes one clock edge after the mask or pending change that causes it.
- R11: A line in general I/O mode holds its pending bit at 0 whatever its pad does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | N | Write data |
| bus_rdata | output | N | Read data for `bus_addr` (combinational) |
| pad_in | input | N | Raw pad levels, asynchronous |
| alt_data | input | N | Alternate output data for lines with source bit 1 |
| pad_out | output | N | Output value per line |
| pad_oe | output | N | Output driver enable per line |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The bench builds the bank with its defaults, N = 32 lines and two synchroniser stages. The full 32-bit word makes the all-ones and all-but-one mask writes meaningful, and the two-stage depth fixes the pad-to-pending latency at exactly three edges, which the bench samples on both sides. A vector table walks line 0 through every combination of polarity, edge/level and dual-edge over both pad transitions. Directed sequences then line a clear write up with a capture in the same cycle, check level-mode clears, the mask pair and the irq delay, output-source and glitch-free switching to output, and input-enable gating.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] A_MODE = 7'h00;
    localparam logic [ADDR_W-1:0] A_DIR  = 7'h04;
    localparam logic [ADDR_W-1:0] A_ODAT = 7'h08;
    localparam logic [ADDR_W-1:0] A_IDAT = 7'h0C;
    localparam logic [ADDR_W-1:0] A_PEND = 7'h10;
    localparam logic [ADDR_W-1:0] A_PCLR = 7'h14;
    localparam logic [ADDR_W-1:0] A_MASK = 7'h18;
    localparam logic [ADDR_W-1:0] A_MSET = 7'h1C;
    localparam logic [ADDR_W-1:0] A_POL  = 7'h20;
    localparam logic [ADDR_W-1:0] A_EDGE = 7'h24;
    localparam logic [ADDR_W-1:0] A_OSEL = 7'h40;
    localparam logic [ADDR_W-1:0] A_BOTH = 7'h4C;
    localparam logic [ADDR_W-1:0] A_INEN = 7'h50;

    typedef enum logic [3:0] {
        RS_MODE, RS_DIR, RS_ODAT, RS_IDAT, RS_PEND, RS_PCLR, RS_MASK,
        RS_MSET, RS_POL, RS_EDGE, RS_OSEL, RS_BOTH, RS_INEN, RS_NONE
    } reg_sel_e;

    typedef enum logic [1:0] {
        TRG_OFF, TRG_LEVEL, TRG_ONE, TRG_BOTH
    } trig_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            A_MODE:  s = RS_MODE;
            A_DIR:   s = RS_DIR;
            A_ODAT:  s = RS_ODAT;
            A_IDAT:  s = RS_IDAT;
            A_PEND:  s = RS_PEND;
            A_PCLR:  s = RS_PCLR;
            A_MASK:  s = RS_MASK;
            A_MSET:  s = RS_MSET;
            A_POL:   s = RS_POL;
            A_EDGE:  s = RS_EDGE;
            A_OSEL:  s = RS_OSEL;
            A_BOTH:  s = RS_BOTH;
            A_INEN:  s = RS_INEN;
            default: s = RS_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect
    import gpio_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic irq_mode,
    input  logic pol,
    input  logic edge_sel,
    input  logic both,
    input  logic clr,
    output logic pend
);
    logic  prev_q;
    logic  rise, fall, hit, pend_d;
    trig_e kind;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

    always_comb begin
        if (!irq_mode)      kind = TRG_OFF;
        else if (!edge_sel) kind = TRG_LEVEL;
        else if (both)      kind = TRG_BOTH;
        else                kind = TRG_ONE;
    end

    always_comb begin
        hit    = 1'b0;
        pend_d = 1'b0;
        unique case (kind)
            TRG_OFF:   pend_d = 1'b0;
            TRG_LEVEL: pend_d = lvl ^ pol;
            TRG_ONE: begin
                hit    = pol ? fall : rise;
                pend_d = hit | (pend & ~clr);
            end
            TRG_BOTH: begin
                hit    = rise | fall;
                pend_d = hit | (pend & ~clr);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= pend_d;
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int N           = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    input  logic [N-1:0]      pad_in,
    input  logic [N-1:0]      alt_data,
    output logic [N-1:0]      pad_out,
    output logic [N-1:0]      pad_oe,
    output logic              irq
);
    logic [N-1:0] mode_q, dir_q, odat_q, pol_q, edge_q, both_q, osel_q, inen_q, mask_q;
    logic [N-1:0] pad_sync, pend, pclr;
    logic         irq_q;
    reg_sel_e     wsel, rsel;

    assign rsel = decode_addr(bus_addr);
    assign wsel = bus_we ? rsel : RS_NONE;
    assign pclr = (wsel == RS_PCLR) ? bus_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0; dir_q  <= '0; odat_q <= '0;
            pol_q  <= '0; edge_q <= '0; both_q <= '0;
            osel_q <= '0; inen_q <= '0; mask_q <= '0;
        end else begin
            unique case (wsel)
                RS_MODE: mode_q <= bus_wdata;
                RS_DIR:  dir_q  <= bus_wdata;
                RS_ODAT: odat_q <= bus_wdata;
                RS_POL:  pol_q  <= bus_wdata;
                RS_EDGE: edge_q <= bus_wdata;
                RS_BOTH: both_q <= bus_wdata;
                RS_OSEL: osel_q <= bus_wdata;
                RS_INEN: inen_q <= bus_wdata;
                RS_MASK: mask_q <= mask_q & bus_wdata;
                RS_MSET: mask_q <= mask_q | bus_wdata;
                default: ;
            endcase
        end
    end

    gpio_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pad_sync)
    );

    for (genvar g = 0; g < N; g++) begin : g_line
        gpio_line_detect u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (pad_sync[g]),
            .irq_mode (mode_q[g]),
            .pol      (pol_q[g]),
            .edge_sel (edge_q[g]),
            .both     (both_q[g]),
            .clr      (pclr[g]),
            .pend     (pend[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(pend & mask_q);
    end
    assign irq = irq_q;

    always_comb begin
        unique case (rsel)
            RS_MODE: bus_rdata = mode_q;
            RS_DIR:  bus_rdata = dir_q;
            RS_ODAT: bus_rdata = odat_q;
            RS_IDAT: bus_rdata = pad_sync & inen_q;
            RS_PEND: bus_rdata = pend;
            RS_MASK: bus_rdata = mask_q;
            RS_POL:  bus_rdata = pol_q;
            RS_EDGE: bus_rdata = edge_q;
            RS_BOTH: bus_rdata = both_q;
            RS_OSEL: bus_rdata = osel_q;
            RS_INEN: bus_rdata = inen_q;
            default: bus_rdata = '0;
        endcase
    end

    assign pad_oe  = dir_q & ~mode_q;
    assign pad_out = (osel_q & alt_data) | (~osel_q & odat_q);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int N = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N-1:0]      bus_rdata,
    input logic [N-1:0]      pad_oe,
    input logic              irq,
    input logic [N-1:0]      mode_q,
    input logic [N-1:0]      mask_q,
    input logic [N-1:0]      inen_q,
    input logic [N-1:0]      pend
);
    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (bus_addr == A_PCLR) |-> (bus_rdata == '0)); // R8
    AST_MASK_WR_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (bus_we && bus_addr == A_MASK) |=> ((mask_q & ~$past(mask_q)) == '0)); // R9
    AST_IRQ_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n) irq |-> ($past(mask_q) != '0)); // R10
    AST_IDATA_GATED: assert property (@(posedge clk) disable iff (!rst_n) (bus_addr == A_IDAT) |-> ((bus_rdata & ~inen_q) == '0)); // R4
    AST_IO_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n) (mode_q != '1) |=> ((pend & ~$past(mode_q)) == '0)); // R11
    AST_OE_OFF_IN_IRQ_MODE: assert property (@(posedge clk) disable iff (!rst_n) (mode_q != '0) |-> ((pad_oe & mode_q) == '0)); // R2
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .mode_q    (mode_q),
    .mask_q    (mask_q),
    .inen_q    (inen_q),
    .pend      (pend)
);

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;
    localparam int N = 32;
    localparam logic [6:0] O_MODE = 7'h00, O_DIR = 7'h04, O_ODAT = 7'h08, O_IDAT = 7'h0C;
    localparam logic [6:0] O_PEND = 7'h10, O_PCLR = 7'h14, O_MASK = 7'h18, O_MSET = 7'h1C;
    localparam logic [6:0] O_POL = 7'h20, O_EDGE = 7'h24, O_FILT = 7'h28, O_OSEL = 7'h40;
    localparam logic [6:0] O_BOTH = 7'h4C, O_INEN = 7'h50;

    // {pol, edge_sense, dual, pad_from, pad_to, expected_pending}
    localparam int NV = 12;
    localparam logic [5:0] VEC [NV] = '{
        6'b010_01_1, 6'b010_10_0, 6'b110_10_1, 6'b110_01_0,
        6'b011_01_1, 6'b011_10_1, 6'b111_10_1, 6'b111_01_1,
        6'b000_01_1, 6'b000_10_0, 6'b100_10_1, 6'b100_01_0
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [6:0]    bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  alt_data = '0;
    logic [N-1:0]  pad_out, pad_oe;
    logic          irq;
    int            n_chk = 0;
    int            n_bad = 0;
    logic [N-1:0]  rv;

    always #4 clk = ~clk;

    gpio_irq_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .alt_data(alt_data), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [N-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        waitn(2);

        // R1: reset state
        begin
            logic [6:0] addrs [14] = '{O_MODE, O_DIR, O_ODAT, O_IDAT, O_PEND, O_PCLR, O_MASK,
                                       O_MSET, O_POL, O_EDGE, O_FILT, O_OSEL, O_BOTH, O_INEN};
            for (int i = 0; i < 14; i++) begin
                rd(addrs[i], rv);
                chk($sformatf("R1 reset reg %h", addrs[i]), rv, '0);
            end
        end
        chk("R1 reset pad_oe", pad_oe, '0);
        chk("R1 reset pad_out", pad_out, '0);
        chk("R1 reset irq", {31'b0, irq}, 32'h0);

        // R5 R6 R7: vector walk on line 0
        for (int v = 0; v < NV; v++) begin
            wr(O_POL,  {31'b0, VEC[v][5]});
            wr(O_EDGE, {31'b0, VEC[v][4]});
            wr(O_BOTH, {31'b0, VEC[v][3]});
            wr(O_MODE, 32'h1);
            pad_in[0] = VEC[v][2];
            waitn(4);
            wr(O_PCLR, 32'h1);
            pad_in[0] = VEC[v][1];
            waitn(4);
            rd(O_PEND, rv);
            chk($sformatf("R5/R6/R7 vector %0d pending", v), {31'b0, rv[0]}, {31'b0, VEC[v][0]});
            chk($sformatf("R10 vector %0d irq masked", v), {31'b0, irq}, 32'h0);
        end

        // R5 latency, R8 zero-write and clear
        wr(O_POL, 32'h0); wr(O_EDGE, 32'h1); wr(O_BOTH, 32'h0); wr(O_MODE, 32'h1);
        pad_in[0] = 1'b0;
        waitn(4);
        wr(O_PCLR, 32'h1);
        pad_in[0] = 1'b1;
        waitn(2);
        rd(O_PEND, rv);
        chk("R5 pending not yet at second edge", {31'b0, rv[0]}, 32'h0);
        waitn(1);
        rd(O_PEND, rv);
        chk("R5 pending at third edge", {31'b0, rv[0]}, 32'h1);
        wr(O_PCLR, 32'h0);
        rd(O_PEND, rv);
        chk("R8 zero write keeps pending", {31'b0, rv[0]}, 32'h1);
        rd(O_PCLR, rv);
        chk("R8 clear word reads zero", rv, '0);
        wr(O_PCLR, 32'h1);
        rd(O_PEND, rv);
        chk("R8 one write clears pending", {31'b0, rv[0]}, 32'h0);

        // R8: capture and clear in the same cycle, capture wins
        pad_in[0] = 1'b0;
        waitn(4);
        wr(O_PCLR, 32'h1);
        pad_in[0] = 1'b1;
        waitn(2);
        bus_we = 1'b1; bus_addr = O_PCLR; bus_wdata = 32'h1;
        @(negedge clk);
        bus_we = 1'b0;
        rd(O_PEND, rv);
        chk("R8 set wins over clear", {31'b0, rv[0]}, 32'h1);
        wr(O_PCLR, 32'h1);

        // R7: level clear has no lasting effect; R9 R10: mask pair and irq timing
        wr(O_EDGE, 32'h0);
        waitn(2);
        wr(O_PCLR, 32'h1);
        waitn(1);
        rd(O_PEND, rv);
        chk("R7 level pending survives clear", {31'b0, rv[0]}, 32'h1);
        chk("R9 masked line no irq", {31'b0, irq}, 32'h0);
        wr(O_MSET, 32'h1);
        chk("R10 irq one edge after mask", {31'b0, irq}, 32'h0);
        waitn(1);
        chk("R10 irq asserted", {31'b0, irq}, 32'h1);
        rd(O_MASK, rv);
        chk("R9 mask reads set bit", rv, 32'h1);
        rd(O_MSET, rv);
        chk("R9 mask-set word reads zero", rv, '0);
        wr(O_MASK, 32'hFFFF_FFFF);
        rd(O_MASK, rv);
        chk("R9 ones to mask keep bits", rv, 32'h1);
        wr(O_MASK, 32'hFFFF_FFFE);
        rd(O_MASK, rv);
        chk("R9 zero to mask clears bit", rv, 32'h0);
        waitn(1);
        chk("R10 irq drops after mask", {31'b0, irq}, 32'h0);

        // R11: general I/O mode keeps pending low
        wr(O_MODE, 32'h0);
        waitn(1);
        rd(O_PEND, rv);
        chk("R11 pending cleared in I/O mode", rv, '0);
        wr(O_EDGE, 32'h1);
        pad_in[0] = 1'b0;
        waitn(4);
        pad_in[0] = 1'b1;
        waitn(4);
        rd(O_PEND, rv);
        chk("R11 pad edges ignored in I/O mode", rv, '0);

        // R2 R3: outputs
        wr(O_ODAT, 32'h20);
        chk("R3 data set before output", {30'b0, pad_out[5], pad_oe[5]}, 32'h2);
        wr(O_DIR, 32'h20);
        chk("R2 output enabled", {30'b0, pad_out[5], pad_oe[5]}, 32'h3);
        alt_data[5] = 1'b0;
        wr(O_OSEL, 32'h20);
        chk("R3 alternate source low", {31'b0, pad_out[5]}, 32'h0);
        alt_data[5] = 1'b1;
        #1;
        chk("R3 alternate source high", {31'b0, pad_out[5]}, 32'h1);
        wr(O_MODE, 32'h20);
        chk("R2 interrupt mode disables driver", {31'b0, pad_oe[5]}, 32'h0);
        wr(O_MODE, 32'h0);

        // R4: input data gating and latency
        pad_in[5] = 1'b1;
        waitn(3);
        rd(O_IDAT, rv);
        chk("R4 gated input reads zero", {31'b0, rv[5]}, 32'h0);
        wr(O_INEN, 32'hA0);
        rd(O_IDAT, rv);
        chk("R4 output line pad visible", {31'b0, rv[5]}, 32'h1);
        pad_in[7] = 1'b1;
        waitn(1);
        rd(O_IDAT, rv);
        chk("R4 not visible after one edge", {31'b0, rv[7]}, 32'h0);
        waitn(1);
        rd(O_IDAT, rv);
        chk("R4 visible after two edges", {31'b0, rv[7]}, 32'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule